// File: doc/BRIEF.md
# Fixed-Latency Writeback Scheduler

This block follows operations that a statically scheduled core has already issued. Each issued operation carries an operation class, a destination register index and a result value that the functional unit computed. The block holds every result for the fixed number of delay slots tied to its class, then presents it on a writeback lane. A register file written from these lanes therefore gives delay-slot behaviour: a consumer issued before the slots have passed still reads the old register value. Nothing stalls; the compiler is expected to respect the slot counts.

Loads and stores go through a small word-addressed data memory inside the block. A store updates memory at its issue edge and never writes a register. A load samples memory at its issue edge, so a load issued before a store returns the old word, and a load issued in any later cycle returns the new word. Each class has its own delay chain and its own retire lane, so results of different classes that come due in the same cycle all retire. When two due results name the same destination, the collision flag rises and only the later-issued result, which is the one with fewer delay slots, stays valid.

Top module: `wb_sched`

## Requirements
- R1: Class code 0 (single-cycle) has zero delay slots: an operation issued at clock edge E retires on lane 0 in the cycle right after E, with its destination and issue data, for exactly one cycle.
- R2: Class code 1 (halfword or non-multiply multiplier operation) has one delay slot: it retires on lane 1 in the second cycle after its issue edge, and not in the first.
- R3: Class code 2 (extended multiply) has three delay slots: it retires on lane 2 in the fourth cycle after its issue edge, and not earlier.
- R4: Class code 3 (load) has four delay slots: it retires on lane 3 in the fifth cycle after its issue edge, with the memory word at the issue address as its data; the issue data field is ignored.
- R5: Class code 4 (store) writes the issue data to memory at the issue address at its issue edge and never raises any retire lane; memory words are zero after reset.
- R6: A load issued in a later cycle than a store to the same address returns the stored word; a load issued before that store returns the previous word.
- R7: An issue with valid low, or with class code 5, 6 or 7, raises no retire lane and leaves memory unchanged.
- R8: When two due results name the same destination in one cycle, the collision flag is high and only the lowest-numbered of those lanes (the later-issued result) is valid.
- R9: Results of different classes due in the same cycle with distinct destinations all retire together and the collision flag stays low.
- R10: Reset holds every retire lane low and discards all pending results, which never retire after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An operation is issued this cycle |
| iss_cls | input | 3 | Operation class code (0 single-cycle, 1 multiply, 2 extended multiply, 3 load, 4 store) |
| iss_dest | input | AW (5) | Destination register index |
| iss_addr | input | MAW (4) | Word address for loads and stores |
| iss_data | input | DW (32) | Result value, or store data |
| ret_valid | output | 4 | Per-lane retire strobe; lane index equals class code |
| ret_dest | output | 4 x AW | Per-lane destination register index |
| ret_data | output | 4 x DW | Per-lane result value |
| collision | output | 1 | Two due results named the same destination this cycle |

## Verification
The assertions watch on every cycle that each lane retires exactly its slot count after the matching issue with the issued destination, that no two live lanes ever name the same register, that a raised collision flag always leaves a later-issued winner visible, and that reset keeps every lane quiet. Memory ordering between loads and stores, the value a load returns, the silence of ignored class codes and the discarding of in-flight results across reset depend on stimulus history, so only the bench's directed scenarios show them.

// File: rtl/wb_pkg.sv
package wb_pkg;

  localparam int NLANE = 4;
  localparam int CW    = 3;

  typedef enum logic [CW-1:0] {
    CLS_ALU   = 3'd0,
    CLS_MUL   = 3'd1,
    CLS_MULX  = 3'd2,
    CLS_LOAD  = 3'd3,
    CLS_STORE = 3'd4
  } wb_cls_e;

  localparam int LOAD_LANE = int'(CLS_LOAD);

  // Delay slots per retire lane; lane index equals class code.
  function automatic int lane_slots(input int lane);
    case (lane)
      0:       return 0;
      1:       return 1;
      2:       return 3;
      default: return 4;
    endcase
  endfunction

  // Register stages a lane needs: one per slot plus the capture stage.
  function automatic int lane_depth(input int lane);
    return lane_slots(lane) + 1;
  endfunction

endpackage

// File: rtl/wb_delay_chain.sv
module wb_delay_chain #(
  parameter int DEPTH = 1,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_dest,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [AW-1:0] out_dest,
  output logic [DW-1:0] out_data
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0]         vld;
  logic [DEPTH-1:0][AW-1:0] dst;
  logic [DEPTH-1:0][DW-1:0] dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      dst <= '0;
      dat <= '0;
    end else begin
      vld[0] <= in_valid;
      dst[0] <= in_dest;
      dat[0] <= in_data;
      for (int s = 1; s < DEPTH; s++) begin
        vld[s] <= vld[s-1];
        dst[s] <= dst[s-1];
        dat[s] <= dat[s-1];
      end
    end
  end

  assign out_valid = vld[LAST];
  assign out_dest  = dst[LAST];
  assign out_data  = dat[LAST];

endmodule

// File: rtl/wb_lsu_mem.sv
module wb_lsu_mem #(
  parameter int MAW = 4,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [MAW-1:0] addr,
  input  logic [DW-1:0]  wr_data,
  output logic [DW-1:0]  rd_data
);

  localparam int WORDS = 1 << MAW;

  logic [DW-1:0] mem [WORDS];

  // Read reflects contents before this edge's write: same-edge reads see old data.
  assign rd_data = mem[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WORDS; w++) mem[w] <= '0;
    end else if (wr_en) begin
      mem[addr] <= wr_data;
    end
  end

endmodule

// File: rtl/wb_retire_merge.sv
module wb_retire_merge #(
  parameter int NL = 4,
  parameter int AW = 5
) (
  input  logic [NL-1:0]         raw_valid,
  input  logic [NL-1:0][AW-1:0] raw_dest,
  output logic [NL-1:0]         live,
  output logic [NL-1:0]         shadowed
);

  // A lane is shadowed when a lower lane (fewer slots, so issued later)
  // retires to the same register in this cycle.
  function automatic logic newer_hit(input logic [NL-1:0] v,
                                     input logic [NL-1:0][AW-1:0] d,
                                     input int lane);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < lane; j++) begin
      if (v[j] && v[lane] && (d[j] == d[lane])) hit = 1'b1;
    end
    return hit;
  endfunction

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign shadowed[l] = newer_hit(raw_valid, raw_dest, l);
    assign live[l]     = raw_valid[l] & ~shadowed[l];
  end

endmodule

// File: rtl/wb_sched.sv
module wb_sched
  import wb_pkg::*;
#(
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int MAW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     iss_valid,
  input  logic [CW-1:0]            iss_cls,
  input  logic [AW-1:0]            iss_dest,
  input  logic [MAW-1:0]           iss_addr,
  input  logic [DW-1:0]            iss_data,
  output logic [NLANE-1:0]         ret_valid,
  output logic [NLANE-1:0][AW-1:0] ret_dest,
  output logic [NLANE-1:0][DW-1:0] ret_data,
  output logic                     collision
);

  // Internal events named for the checker.
  logic                     store_fire;
  logic [DW-1:0]            load_word;
  logic [NLANE-1:0]         lane_fire;
  logic [NLANE-1:0]         raw_valid;
  logic [NLANE-1:0]         shadowed;

  assign store_fire = iss_valid && (iss_cls == CLS_STORE);

  wb_lsu_mem #(.MAW(MAW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_fire),
    .addr    (iss_addr),
    .wr_data (iss_data),
    .rd_data (load_word)
  );

  for (genvar l = 0; l < NLANE; l++) begin : g_chain
    localparam int DEPTH = lane_depth(l);
    logic [DW-1:0] lane_in;

    assign lane_fire[l] = iss_valid && (iss_cls == CW'(l));

    if (l == LOAD_LANE) begin : g_ld
      assign lane_in = load_word;
    end else begin : g_op
      assign lane_in = iss_data;
    end

    wb_delay_chain #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (lane_fire[l]),
      .in_dest   (iss_dest),
      .in_data   (lane_in),
      .out_valid (raw_valid[l]),
      .out_dest  (ret_dest[l]),
      .out_data  (ret_data[l])
    );
  end

  wb_retire_merge #(.NL(NLANE), .AW(AW)) u_merge (
    .raw_valid (raw_valid),
    .raw_dest  (ret_dest),
    .live      (ret_valid),
    .shadowed  (shadowed)
  );

  assign collision = |shadowed;

endmodule

// File: rtl/wb_sched_chk.sv
module wb_sched_chk
  import wb_pkg::*;
#(
  parameter int AW  = 5,
  parameter int DW  = 32,
  parameter int MAW = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     iss_valid,
  input logic [CW-1:0]            iss_cls,
  input logic [AW-1:0]            iss_dest,
  input logic [DW-1:0]            iss_data,
  input logic [NLANE-1:0]         ret_valid,
  input logic [NLANE-1:0][AW-1:0] ret_dest,
  input logic                     collision,
  input logic [NLANE-1:0]         lane_fire
);

  logic dup_live;
  always_comb begin
    dup_live = 1'b0;
    for (int a = 0; a < NLANE; a++)
      for (int b = a + 1; b < NLANE; b++)
        if (ret_valid[a] && ret_valid[b] && ret_dest[a] == ret_dest[b]) dup_live = 1'b1;
  end

  // R1
  alu_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_cls == CLS_ALU) |=> (ret_valid[0] && ret_dest[0] == $past(iss_dest)));

  // R1
  alu_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[0] |-> $past(iss_valid && iss_cls == CLS_ALU));

  // R2
  mul_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fire[1] |=> ##1 ((ret_valid[1] || collision) && ret_dest[1] == $past(iss_dest, 2)));

  // R3
  mulx_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fire[2] |=> ##3 ((ret_valid[2] || collision) && ret_dest[2] == $past(iss_dest, 4)));

  // R4
  load_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lane_fire[3] |=> ##4 ((ret_valid[3] || collision) && ret_dest[3] == $past(iss_dest, 5)));

  // R8
  no_dup_dest_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_live);

  // R8
  collision_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (ret_valid[0] || ret_valid[1] || ret_valid[2]));

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (ret_valid == '0 && !collision));

endmodule

bind wb_sched wb_sched_chk #(.AW(AW), .DW(DW), .MAW(MAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_cls   (iss_cls),
  .iss_dest  (iss_dest),
  .iss_data  (iss_data),
  .ret_valid (ret_valid),
  .ret_dest  (ret_dest),
  .collision (collision),
  .lane_fire (lane_fire)
);

// File: tb/wb_sched_test.sv
module wb_sched_test;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int MAW = 4;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 iss_valid = 1'b0;
  logic [2:0]           iss_cls = '0;
  logic [AW-1:0]        iss_dest = '0;
  logic [MAW-1:0]       iss_addr = '0;
  logic [DW-1:0]        iss_data = '0;
  logic [3:0]           ret_valid;
  logic [3:0][AW-1:0]   ret_dest;
  logic [3:0][DW-1:0]   ret_data;
  logic                 collision;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wb_sched #(.AW(AW), .DW(DW), .MAW(MAW)) uut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_cls(iss_cls),
    .iss_dest(iss_dest), .iss_addr(iss_addr), .iss_data(iss_data),
    .ret_valid(ret_valid), .ret_dest(ret_dest), .ret_data(ret_data),
    .collision(collision)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] c, input int d, input int a, input logic [DW-1:0] v);
    iss_valid = 1'b1;
    iss_cls   = c;
    iss_dest  = AW'(d);
    iss_addr  = MAW'(a);
    iss_data  = v;
  endtask

  task automatic idle();
    iss_valid = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 lanes quiet after reset", 64'(ret_valid), 64'h0);
    check("R10 collision low after reset", 64'(collision), 64'h0);
  endtask

  task automatic t_alu();
    put(3'd0, 3, 0, 32'hA1A1_0003); tick(); idle();
    check("R1 alu lane0 valid", 64'(ret_valid), 64'h1);
    check("R1 alu dest", 64'(ret_dest[0]), 64'd3);
    check("R1 alu data", 64'(ret_data[0]), 64'hA1A1_0003);
    tick();
    check("R1 alu single pulse", 64'(ret_valid), 64'h0);
  endtask

  task automatic t_mul();
    put(3'd1, 4, 0, 32'h0000_BEE4); tick(); idle();
    check("R2 mul not early", 64'(ret_valid), 64'h0);
    tick();
    check("R2 mul lane1 valid", 64'(ret_valid), 64'h2);
    check("R2 mul data", 64'(ret_data[1]), 64'h0000_BEE4);
  endtask

  task automatic t_mulx();
    put(3'd2, 6, 0, 32'h1234_5678); tick(); idle();
    tick(); tick();
    check("R3 mulx not early", 64'(ret_valid), 64'h0);
    tick();
    check("R3 mulx lane2 valid", 64'(ret_valid), 64'h4);
    check("R3 mulx dest", 64'(ret_dest[2]), 64'd6);
    check("R3 mulx data", 64'(ret_data[2]), 64'h1234_5678);
  endtask

  task automatic t_store_load();
    put(3'd4, 0, 5, 32'h5555_AAAA); tick(); idle();
    check("R5 store raises no lane", 64'(ret_valid), 64'h0);
    put(3'd3, 7, 5, 32'hFFFF_FFFF); tick(); idle();
    tick(); tick(); tick();
    check("R4 load not early", 64'(ret_valid), 64'h0);
    tick();
    check("R4 load lane3 valid", 64'(ret_valid), 64'h8);
    check("R4 load dest", 64'(ret_dest[3]), 64'd7);
    check("R6 load after store sees new word", 64'(ret_data[3]), 64'h5555_AAAA);
  endtask

  task automatic t_load_before_store();
    put(3'd4, 0, 9, 32'h0000_0A0A); tick();
    put(3'd3, 8, 9, 32'h0); tick();
    put(3'd4, 0, 9, 32'h0000_0B0B); tick(); idle();
    tick(); tick(); tick();
    check("R6 load before store sees old word", 64'(ret_data[3]), 64'h0000_0A0A);
    put(3'd3, 8, 9, 32'h0); tick(); idle();
    tick(); tick(); tick(); tick();
    check("R6 later load sees second store", 64'(ret_data[3]), 64'h0000_0B0B);
  endtask

  task automatic t_ignored();
    int quiet;
    put(3'd5, 1, 2, 32'hDEAD_0005); tick();
    put(3'd4, 1, 2, 32'hDEAD_0004); iss_valid = 1'b0; tick();
    put(3'd0, 1, 2, 32'hDEAD_0000); iss_valid = 1'b0; tick();
    put(3'd7, 1, 2, 32'hDEAD_0007); tick(); idle();
    quiet = 0;
    for (int k = 0; k < 6; k++) begin
      if (ret_valid != 4'h0) quiet++;
      tick();
    end
    check("R7 ignored issues raise no lane", 64'(quiet), 64'd0);
    put(3'd3, 2, 2, 32'h0); tick(); idle();
    tick(); tick(); tick(); tick();
    check("R7 memory untouched by ignored issues", 64'(ret_data[3]), 64'h0);
  endtask

  task automatic t_collision();
    put(3'd3, 10, 3, 32'h0); tick(); idle();
    tick(); tick(); tick();
    put(3'd0, 10, 0, 32'hC0C0_0010); tick(); idle();
    check("R8 only newer lane valid", 64'(ret_valid), 64'h1);
    check("R8 collision flag", 64'(collision), 64'h1);
    check("R8 newer data wins", 64'(ret_data[0]), 64'hC0C0_0010);
    tick();
    check("R8 collision clears", 64'(collision), 64'h0);
  endtask

  task automatic t_multi();
    put(3'd3, 11, 5, 32'h0); tick();
    put(3'd2, 12, 0, 32'h2222_0012); tick(); idle();
    tick();
    put(3'd1, 13, 0, 32'h1111_0013); tick();
    put(3'd0, 14, 0, 32'h0000_0014); tick(); idle();
    check("R9 all lanes retire", 64'(ret_valid), 64'hF);
    check("R9 no collision", 64'(collision), 64'h0);
    check("R9 load data", 64'(ret_data[3]), 64'h5555_AAAA);
    check("R9 mulx data", 64'(ret_data[2]), 64'h2222_0012);
    check("R9 mul dest", 64'(ret_dest[1]), 64'd13);
    check("R9 alu data", 64'(ret_data[0]), 64'h0000_0014);
  endtask

  task automatic t_flush();
    int seen;
    put(3'd3, 15, 5, 32'h0); tick();
    put(3'd2, 16, 0, 32'h6666_0016); tick(); idle();
    rst_n = 1'b0; tick();
    check("R10 lanes quiet in reset", 64'(ret_valid), 64'h0);
    rst_n = 1'b1;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (ret_valid != 4'h0) seen++;
    end
    check("R10 pending results discarded", 64'(seen), 64'd0);
    put(3'd3, 17, 5, 32'h0); tick(); idle();
    tick(); tick(); tick(); tick();
    check("R5 memory zero after reset", 64'(ret_data[3]), 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_alu();
    t_mul();
    t_mulx();
    t_store_load();
    t_load_before_store();
    t_ignored();
    t_collision();
    t_multi();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule